// File: doc/BRIEF.md
# Descriptor Cache Save/Restore Engine

This block moves one entry of a processor's hidden segment-descriptor cache between the cache and a packed 10-byte image in memory. A command names the direction (save writes the image, restore reads it back) and a target: one of the five data segment registers (picked by the 3-bit register field of a mod/reg/rm byte), the local descriptor table register, or the task register. Together with the command come the mod/reg/rm byte, an already computed effective address and the processor mode (protected mode, virtual-8086 mode, current privilege level).

Legality is decided when the command is accepted. An illegal form or mode ends the command with a one-cycle invalid-opcode indication (vector 6). A privileged restore at a nonzero privilege level ends it with a general-protection indication (vector 13, error code zero). In both cases no memory traffic takes place. A legal command walks the ten image bytes over a byte-wide request/acknowledge port. In the image, the limit is scaled down by the granularity bit on save and expanded again on restore, and the attribute word overlays part of the base field. A restore writes the cache entry in a single cycle after the last byte has arrived. A combinational lookup port gives the rest of the processor the cached values of any entry.

Top module: `seg_image_engine`

## Requirements
- R1: A save writes the image bytes as follows: offsets 0-1 hold the scaled limit (low byte first), offsets 2-4 hold base bits 23:0, offsets 5-6 hold the attribute word (low byte first), offset 7 holds base bits 31:24, and offsets 8-9 hold the selector (low byte first). After reset every cache entry is zero.
- R2: Attribute bit 15 is the granularity flag. When it is set, a save stores bits 27:12 of the cached limit. When it is clear, a save stores bits 15:0.
- R3: A restore forms the limit from offsets 0-1 as bits 15:0 and attribute bits 1:0 as bits 17:16. When the granularity flag is set, that value is shifted left by 12 and its low 12 bits are filled with ones.
- R4: A restore sets the base from offsets 2-4 (bits 23:0) and offset 7 (bits 31:24), the attribute word from offsets 5-6 and the selector from offsets 8-9.
- R5: cmd_target encoding is 0 = data segment register, 1 = local table register, 2 = task register, 3 = invalid opcode. For target 0, register field (mod/rm bits 5:3) values 0, 2, 3, 4 and 5 select lookup entries 0 to 4 (ES, SS, DS, FS, GS). Any other field value ends the command with fault_ud and fault_vec = 6. Lookup indices 5 and 6 are the local table register and the task register. Index 7 reads as zero.
- R6: For target 0, a mod field (bits 7:6) of 3 ends the command with fault_ud and no memory request. Other mod values are accepted.
- R7: For targets 1 and 2, mod/rm bits 7:3 must all be zero, or the command ends with fault_ud. Bits 2:0 are not checked.
- R8: Target 1 requires prot_mode = 1 and v86_mode = 0. Target 2 requires prot_mode = 1. A violation gives fault_ud, and this check ranks above the privilege check.
- R9: A restore to target 1 or 2 with cpl != 0 (and a legal mode) gives fault_gp with fault_vec = 13, performs no memory access and leaves the entry unchanged. A save ignores cpl.
- R10: A legal command makes exactly ten byte transfers at addresses ea+0 to ea+9 in ascending order, one per cycle in which mem_req and mem_ack are both high. mem_req, mem_addr and mem_we hold steady while mem_ack is low.
- R11: A restore changes the cache entry only in the cycle after the last byte has been received. Lookups show the old contents until then.
- R12: busy rises in the cycle after a command is accepted and stays high up to and including a single-cycle done, fault_ud or fault_gp pulse. It is low in the next cycle. A cmd_valid seen while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_restore | input | 1 | 1 = restore from memory, 0 = save to memory |
| cmd_target | input | 2 | 0 segment register, 1 local table register, 2 task register |
| cmd_modrm | input | 8 | mod/reg/rm byte of the instruction |
| cmd_ea | input | ADDR_W | Effective address of image byte 0 |
| prot_mode | input | 1 | Protected mode active |
| v86_mode | input | 1 | Virtual-8086 mode active |
| cpl | input | 2 | Current privilege level |
| mem_req | output | 1 | Byte transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Transfer completes in this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_ud | output | 1 | One-cycle invalid-opcode pulse |
| fault_gp | output | 1 | One-cycle general-protection pulse |
| fault_vec | output | 8 | Fault vector (6 or 13) during a fault pulse, else 0 |
| look_idx | input | 3 | Cache entry to read on the lookup port |
| look_limit | output | 32 | Cached limit of that entry |
| look_base | output | 32 | Cached base of that entry |
| look_attr | output | 16 | Cached attribute word of that entry |
| look_sel | output | 16 | Cached selector of that entry |

## Verification
Two things can fall in the same cycle. The done pulse can coincide with a new command strobe, and the restore commit can coincide with a lookup of the same entry. The bench raises cmd_valid, carrying a legal restore, exactly in the cycle where done is seen. It judges the result by busy dropping in the next cycle and by no further memory transfer occurring. For the commit, it reads the target entry through the lookup port in the middle of a restore and again right after the done pulse. It expects the old value at the first read and the new value only at the second.

// File: rtl/segimg_pkg.sv
package segimg_pkg;

  localparam int IMG_BYTES     = 10;
  localparam int IMG_BITS      = IMG_BYTES * 8;
  localparam int CACHE_ENTRIES = 7;
  localparam int IDX_W         = 3;
  localparam int GRAN_SHIFT    = 12;
  localparam int GRAN_BIT      = 15;

  localparam logic [1:0] TGT_SEG = 2'd0;
  localparam logic [1:0] TGT_LDT = 2'd1;
  localparam logic [1:0] TGT_TSK = 2'd2;

  localparam logic [IDX_W-1:0] ENT_ES  = 3'd0;
  localparam logic [IDX_W-1:0] ENT_SS  = 3'd1;
  localparam logic [IDX_W-1:0] ENT_DS  = 3'd2;
  localparam logic [IDX_W-1:0] ENT_FS  = 3'd3;
  localparam logic [IDX_W-1:0] ENT_GS  = 3'd4;
  localparam logic [IDX_W-1:0] ENT_LDT = 3'd5;
  localparam logic [IDX_W-1:0] ENT_TSK = 3'd6;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_GP = 8'd13;

  typedef enum logic [1:0] {CHK_OK, CHK_UD, CHK_GP} chk_e;

  typedef struct packed {
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] limit;
    logic [15:0] attr;
  } seg_ent_t;

  // limit as stored in the image: page units when granular
  function automatic logic [15:0] scale_limit(input logic [31:0] lim, input logic gran);
    return 16'(gran ? (lim >> GRAN_SHIFT) : lim);
  endfunction

  // limit rebuilt from the image: 18 bits, optionally widened to bytes
  function automatic logic [31:0] expand_limit(input logic [15:0] lo, input logic [1:0] hi,
                                               input logic gran);
    logic [31:0] raw;
    raw = {14'd0, hi, lo};
    if (gran) return (raw << GRAN_SHIFT) | ((32'd1 << GRAN_SHIFT) - 32'd1);
    return raw;
  endfunction

  // byte k of the image sits at bits 8k+7:8k
  function automatic logic [IMG_BITS-1:0] pack_image(input seg_ent_t e);
    return {e.sel, e.base[31:24], e.attr, e.base[23:0], scale_limit(e.limit, e.attr[GRAN_BIT])};
  endfunction

  function automatic seg_ent_t unpack_image(input logic [IMG_BITS-1:0] img);
    seg_ent_t e;
    e.attr  = img[55:40];
    e.base  = {img[63:56], img[39:16]};
    e.limit = expand_limit(img[15:0], img[41:40], img[40+GRAN_BIT]);
    e.sel   = img[79:64];
    return e;
  endfunction

endpackage

// File: rtl/seg_op_check.sv
module seg_op_check
  import segimg_pkg::*;
(
  input  logic             restore,
  input  logic [1:0]       target,
  input  logic [7:0]       modrm,
  input  logic             prot_mode,
  input  logic             v86_mode,
  input  logic [1:0]       cpl,
  output chk_e             verdict,
  output logic [IDX_W-1:0] ent_idx
);

  logic       field_bad;
  logic       reg_operand;
  logic       upper_nonzero;
  logic       priv_restore;
  logic       unused_rm_bits;

  assign reg_operand    = (modrm[7:6] == 2'b11);
  assign upper_nonzero  = (modrm[7:3] != 5'd0);
  assign priv_restore   = restore && (cpl != 2'd0);
  assign unused_rm_bits = ^modrm[2:0];

  always_comb begin
    field_bad = 1'b0;
    ent_idx   = ENT_ES;
    verdict   = CHK_OK;
    case (target)
      TGT_SEG: begin
        case (modrm[5:3])
          3'd0:    ent_idx = ENT_ES;
          3'd2:    ent_idx = ENT_SS;
          3'd3:    ent_idx = ENT_DS;
          3'd4:    ent_idx = ENT_FS;
          3'd5:    ent_idx = ENT_GS;
          default: field_bad = 1'b1;
        endcase
        if (reg_operand || field_bad) verdict = CHK_UD;
      end
      TGT_LDT: begin
        ent_idx = ENT_LDT;
        if (!prot_mode || v86_mode) verdict = CHK_UD;
        else if (priv_restore)      verdict = CHK_GP;
        else if (upper_nonzero)     verdict = CHK_UD;
      end
      TGT_TSK: begin
        ent_idx = ENT_TSK;
        if (!prot_mode)             verdict = CHK_UD;
        else if (priv_restore)      verdict = CHK_GP;
        else if (upper_nonzero)     verdict = CHK_UD;
      end
      default: verdict = CHK_UD;
    endcase
  end

endmodule

// File: rtl/seg_cache_file.sv
module seg_cache_file
  import segimg_pkg::*;
#(
  parameter int ENTRIES = CACHE_ENTRIES,
  parameter int IW      = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  seg_ent_t      wr_data,
  input  logic [IW-1:0] rd_a_idx,
  output seg_ent_t      rd_a_ent,
  input  logic [IW-1:0] rd_b_idx,
  output seg_ent_t      rd_b_ent
);

  seg_ent_t ent_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (wr_en && (wr_idx < IW'(ENTRIES))) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  assign rd_a_ent = (rd_a_idx < IW'(ENTRIES)) ? ent_q[rd_a_idx] : '0;
  assign rd_b_ent = (rd_b_idx < IW'(ENTRIES)) ? ent_q[rd_b_idx] : '0;

endmodule

// File: rtl/seg_byte_walker.sv
module seg_byte_walker #(
  parameter int NBYTES = 10,
  parameter int ADDR_W = 32,
  localparam int CNT_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              ack,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  idx,
  output logic              step,
  output logic              last_step
);

  logic              run_q;
  logic [CNT_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              at_last;

  assign at_last   = (idx_q == CNT_W'(NBYTES - 1));
  assign step      = run_q && ack;
  assign last_step = step && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (start) begin
      run_q  <= 1'b1;
      idx_q  <= '0;
      base_q <= base_addr;
    end else if (step) begin
      idx_q <= idx_q + 1'b1;
      if (at_last) run_q <= 1'b0;
    end
  end

  assign req  = run_q;
  assign idx  = idx_q;
  assign addr = base_q + ADDR_W'(idx_q);

endmodule

// File: rtl/seg_image_engine.sv
module seg_image_engine
  import segimg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_restore,
  input  logic [1:0]        cmd_target,
  input  logic [7:0]        cmd_modrm,
  input  logic [ADDR_W-1:0] cmd_ea,
  input  logic              prot_mode,
  input  logic              v86_mode,
  input  logic [1:0]        cpl,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fault_ud,
  output logic              fault_gp,
  output logic [7:0]        fault_vec,
  input  logic [IDX_W-1:0]  look_idx,
  output logic [31:0]       look_limit,
  output logic [31:0]       look_base,
  output logic [15:0]       look_attr,
  output logic [15:0]       look_sel
);

  localparam int CNT_W = $clog2(IMG_BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_DONE, ST_TRAP} st_e;

  st_e                 st_q;
  logic                op_restore_q;
  logic                trap_gp_q;
  logic [IDX_W-1:0]    ent_q;
  logic [IMG_BITS-1:0] rbuf_q;

  chk_e                verdict;
  logic [IDX_W-1:0]    chk_ent;
  seg_ent_t            save_ent;
  seg_ent_t            look_ent;
  logic [IMG_BITS-1:0] save_img;
  logic [CNT_W-1:0]    byte_idx;

  // named events for the bound checker
  logic accept;
  logic xfer_step;
  logic xfer_last;
  logic commit_en;
  logic walk_start;

  assign accept     = cmd_valid && (st_q == ST_IDLE);
  assign walk_start = accept && (verdict == CHK_OK);
  assign commit_en  = (st_q == ST_DONE) && op_restore_q;

  seg_op_check u_check (
    .restore   (cmd_restore),
    .target    (cmd_target),
    .modrm     (cmd_modrm),
    .prot_mode (prot_mode),
    .v86_mode  (v86_mode),
    .cpl       (cpl),
    .verdict   (verdict),
    .ent_idx   (chk_ent)
  );

  seg_byte_walker #(.NBYTES(IMG_BYTES), .ADDR_W(ADDR_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (walk_start),
    .base_addr (cmd_ea),
    .ack       (mem_ack),
    .req       (mem_req),
    .addr      (mem_addr),
    .idx       (byte_idx),
    .step      (xfer_step),
    .last_step (xfer_last)
  );

  seg_cache_file #(.ENTRIES(CACHE_ENTRIES), .IW(IDX_W)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_en),
    .wr_idx   (ent_q),
    .wr_data  (unpack_image(rbuf_q)),
    .rd_a_idx (ent_q),
    .rd_a_ent (save_ent),
    .rd_b_idx (look_idx),
    .rd_b_ent (look_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      op_restore_q <= 1'b0;
      trap_gp_q    <= 1'b0;
      ent_q        <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          op_restore_q <= cmd_restore;
          ent_q        <= chk_ent;
          trap_gp_q    <= (verdict == CHK_GP);
          st_q         <= (verdict == CHK_OK) ? ST_MOVE : ST_TRAP;
        end
        ST_MOVE: if (xfer_last) st_q <= ST_DONE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // restore staging: nothing reaches the cache before the last byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
    end else if (xfer_step && op_restore_q) begin
      rbuf_q[8*byte_idx +: 8] <= mem_rdata;
    end
  end

  assign save_img  = pack_image(save_ent);
  assign mem_wdata = save_img[8*byte_idx +: 8];
  assign mem_we    = mem_req && !op_restore_q;

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign fault_ud  = (st_q == ST_TRAP) && !trap_gp_q;
  assign fault_gp  = (st_q == ST_TRAP) && trap_gp_q;
  assign fault_vec = (st_q != ST_TRAP) ? 8'd0 : (trap_gp_q ? VEC_GP : VEC_UD);

  assign look_limit = look_ent.limit;
  assign look_base  = look_ent.base;
  assign look_attr  = look_ent.attr;
  assign look_sel   = look_ent.sel;

endmodule

// File: rtl/seg_image_engine_chk.sv
module seg_image_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept,
  input logic              commit_en,
  input logic              cmd_restore,
  input logic [1:0]        cmd_target,
  input logic [7:0]        cmd_modrm,
  input logic              prot_mode,
  input logic              v86_mode,
  input logic [1:0]        cpl,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              done,
  input logic              fault_ud,
  input logic              fault_gp
);

  AST_REG_OPERAND_UD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_target == 2'd0 && cmd_modrm[7:6] == 2'b11 |=> fault_ud && !mem_req); // R6

  AST_LDT_MODE_UD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_target == 2'd1 && (!prot_mode || v86_mode) |=> fault_ud); // R8

  AST_PRIV_RESTORE_GP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cmd_restore && cmd_target == 2'd2 && prot_mode && cpl != 2'd0 |=> fault_gp && !mem_req); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req || (mem_addr == $past(mem_addr) + 1'b1)); // R10

  AST_COMMIT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> $past(mem_req && mem_ack) && !mem_req); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R12

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done && !fault_ud && !fault_gp |=> busy); // R12

endmodule

bind seg_image_engine seg_image_engine_chk #(.ADDR_W(ADDR_W)) u_engine_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .accept      (accept),
  .commit_en   (commit_en),
  .cmd_restore (cmd_restore),
  .cmd_target  (cmd_target),
  .cmd_modrm   (cmd_modrm),
  .prot_mode   (prot_mode),
  .v86_mode    (v86_mode),
  .cpl         (cpl),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .busy        (busy),
  .done        (done),
  .fault_ud    (fault_ud),
  .fault_gp    (fault_gp)
);

// File: tb/test_seg_image_engine.sv
module test_seg_image_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_restore = 1'b0;
  logic [1:0]  cmd_target = 2'd0;
  logic [7:0]  cmd_modrm = 8'd0;
  logic [31:0] cmd_ea = 32'd0;
  logic        prot_mode = 1'b0;
  logic        v86_mode = 1'b0;
  logic [1:0]  cpl = 2'd0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic        busy, done, fault_ud, fault_gp;
  logic [7:0]  fault_vec;
  logic [2:0]  look_idx = 3'd0;
  logic [31:0] look_limit, look_base;
  logic [15:0] look_attr, look_sel;

  int checks = 0;
  int errs = 0;
  int xfers = 0;
  logic [7:0] mem [256];
  logic stall_en = 1'b0;
  logic stall_tog = 1'b0;

  always #4 clk = ~clk;

  seg_image_engine i_seg_image_engine (.*);

  // byte memory: acknowledge decided at the falling edge, writes taken at the rising edge
  always @(negedge clk) begin
    mem_ack   = mem_req && (!stall_en || stall_tog);
    mem_rdata = mem[mem_addr[7:0]];
    stall_tog = !stall_tog;
  end

  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      xfers <= xfers + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_img(input logic [7:0] at, input logic [79:0] img);
    for (int k = 0; k < 10; k++) mem[at + 8'(k)] = img[8*k +: 8];
  endtask

  function automatic logic [79:0] get_img(input logic [7:0] at);
    logic [79:0] r;
    for (int k = 0; k < 10; k++) r[8*k +: 8] = mem[at + 8'(k)];
    return r;
  endfunction

  // kind: 0 done, 1 invalid opcode, 2 general protection
  task automatic run_cmd(input logic op, input logic [1:0] tgt, input logic [7:0] mrm,
                         input logic [7:0] ea, input logic pm, input logic v8,
                         input logic [1:0] pl, output int kind, output int nx,
                         output logic [7:0] fv);
    int start_x;
    int n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_restore = op; cmd_target = tgt; cmd_modrm = mrm;
    cmd_ea = {24'd0, ea}; prot_mode = pm; v86_mode = v8; cpl = pl;
    start_x = xfers;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0; kind = -1; fv = 8'd0;
    while (kind < 0 && n < 400) begin
      if (done) kind = 0;
      else if (fault_ud) kind = 1;
      else if (fault_gp) kind = 2;
      if (kind >= 0) fv = fault_vec;
      else begin @(negedge clk); n++; end
    end
    if (kind < 0) begin
      checks++; errs++;
      $display("FAIL command hang actual=none expected=done_or_fault");
    end
    nx = xfers - start_x;
  endtask

  // {req number, restore, target, modrm, prot, v86, cpl, expected kind}
  localparam int NV = 18;
  localparam logic [20:0] VECS [NV] = '{
    {4'd6,  1'b0, 2'd0, 8'hC0, 1'b1, 1'b0, 2'd0, 2'd1},  // R6 register operand
    {4'd5,  1'b0, 2'd0, 8'h08, 1'b1, 1'b0, 2'd0, 2'd1},  // R5 code segment field
    {4'd5,  1'b1, 2'd0, 8'h30, 1'b0, 1'b0, 2'd0, 2'd1},  // R5 field 6
    {4'd5,  1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 2'd0},  // R5 ES
    {4'd5,  1'b0, 2'd0, 8'h28, 1'b0, 1'b0, 2'd3, 2'd0},  // R5 GS
    {4'd7,  1'b0, 2'd1, 8'h08, 1'b1, 1'b0, 2'd0, 2'd1},  // R7 upper bits set
    {4'd8,  1'b0, 2'd1, 8'h03, 1'b1, 1'b1, 2'd0, 2'd1},  // R8 LDT in v86
    {4'd8,  1'b0, 2'd1, 8'h03, 1'b0, 1'b0, 2'd0, 2'd1},  // R8 LDT in real mode
    {4'd8,  1'b0, 2'd2, 8'h00, 1'b1, 1'b1, 2'd0, 2'd0},  // R8 TR save in v86 ok
    {4'd8,  1'b0, 2'd2, 8'h00, 1'b0, 1'b0, 2'd0, 2'd1},  // R8 TR in real mode
    {4'd9,  1'b1, 2'd1, 8'h00, 1'b1, 1'b0, 2'd3, 2'd2},  // R9 LDT restore cpl3
    {4'd9,  1'b1, 2'd2, 8'h00, 1'b1, 1'b0, 2'd1, 2'd2},  // R9 TR restore cpl1
    {4'd7,  1'b1, 2'd2, 8'h10, 1'b1, 1'b0, 2'd0, 2'd1},  // R7 TR restore bad form
    {4'd8,  1'b1, 2'd1, 8'h00, 1'b0, 1'b0, 2'd3, 2'd1},  // R8 mode ranks above privilege
    {4'd5,  1'b0, 2'd3, 8'h00, 1'b1, 1'b0, 2'd0, 2'd1},  // R5 target 3
    {4'd9,  1'b0, 2'd1, 8'h07, 1'b1, 1'b0, 2'd3, 2'd0},  // R9 save ignores cpl, R7 rm bits free
    {4'd6,  1'b0, 2'd0, 8'hF8, 1'b1, 1'b0, 2'd0, 2'd1},  // R6 mod 3 with bad field
    {4'd6,  1'b0, 2'd0, 8'h98, 1'b0, 1'b0, 2'd0, 2'd0}   // R6 mod 2 accepted (DS)
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    int kind;
    int nx;
    int n;
    int x0;
    logic [7:0] fv;
    logic [79:0] img_a;
    logic [79:0] img_b;

    for (int a = 0; a < 256; a++) mem[a] = 8'hAA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 busy after reset", {31'd0, busy}, 32'd0);
    chk("R12 done after reset", {31'd0, done}, 32'd0);
    chk("R10 no request after reset", {31'd0, mem_req}, 32'd0);

    // R1 reset contents seen through a save
    run_cmd(1'b0, 2'd0, 8'h00, 8'h10, 1'b0, 1'b0, 2'd0, kind, nx, fv);
    chk("R1 reset save kind", 32'(kind), 32'd0);
    chk("R1 reset image low", get_img(8'h10)[31:0], 32'd0);
    chk("R1 reset image high", {get_img(8'h10)[79:64], get_img(8'h10)[47:32]}, 32'd0);

    // table of legality cases
    for (int v = 0; v < NV; v++) begin
      run_cmd(VECS[v][16], VECS[v][15:14], VECS[v][13:6], 8'h80,
              VECS[v][5], VECS[v][4], VECS[v][3:2], kind, nx, fv);
      checks++;
      if (kind != int'(VECS[v][1:0])) begin
        errs++;
        $display("FAIL R%0d vector %0d kind actual=%0d expected=%0d", VECS[v][20:17], v, kind,
                 VECS[v][1:0]);
      end
      checks++;
      if (nx != ((VECS[v][1:0] == 2'd0) ? 10 : 0) ||
          fv != ((VECS[v][1:0] == 2'd2) ? 8'd13 : (VECS[v][1:0] == 2'd1) ? 8'd6 : 8'd0)) begin
        errs++;
        $display("FAIL R%0d vector %0d transfers/vector actual=%0d/%0d expected kind %0d",
                 VECS[v][20:17], v, nx, fv, VECS[v][1:0]);
      end
    end

    // R3 R4 restore DS without granularity
    img_a = {16'h0123, 8'hAB, 16'h0093, 24'h345678, 16'h1234};
    put_img(8'h20, img_a);
    run_cmd(1'b1, 2'd0, 8'h18, 8'h20, 1'b0, 1'b0, 2'd0, kind, nx, fv);
    chk("R10 restore DS transfers", 32'(nx), 32'd10);
    @(negedge clk);
    look_idx = 3'd2;
    #1;
    chk("R3 DS limit", look_limit, 32'h0003_1234);
    chk("R4 DS base", look_base, 32'hAB34_5678);
    chk("R4 DS attr", {16'd0, look_attr}, 32'h0093);
    chk("R4 DS selector", {16'd0, look_sel}, 32'h0123);

    // R1 save DS gives the same image back
    run_cmd(1'b0, 2'd0, 8'h18, 8'h40, 1'b0, 1'b0, 2'd0, kind, nx, fv);
    img_b = get_img(8'h40);
    chk("R1 DS image bytes 0-3", img_b[31:0], img_a[31:0]);
    chk("R1 DS image bytes 4-7", img_b[63:32], img_a[63:32]);
    chk("R1 DS image bytes 8-9", {16'd0, img_b[79:64]}, {16'd0, img_a[79:64]});

    // R3 granular restore of FS, R2 scaled save with a stalling memory
    img_a = {16'h0057, 8'h44, 16'h8002, 24'h332211, 16'h0FFF};
    put_img(8'h30, img_a);
    stall_en = 1'b1;
    run_cmd(1'b1, 2'd0, 8'h20, 8'h30, 1'b0, 1'b0, 2'd0, kind, nx, fv);
    @(negedge clk);
    look_idx = 3'd3;
    #1;
    chk("R3 FS granular limit", look_limit, 32'h20FF_FFFF);
    chk("R4 FS base", look_base, 32'h4433_2211);
    run_cmd(1'b0, 2'd0, 8'h20, 8'h60, 1'b0, 1'b0, 2'd0, kind, nx, fv);
    stall_en = 1'b0;
    chk("R10 stalled save transfers", 32'(nx), 32'd10);
    img_b = get_img(8'h60);
    chk("R2 FS scaled limit bytes", {16'd0, img_b[15:0]}, 32'h0FFF);
    chk("R1 FS attr over base bytes 5-7", {8'd0, img_b[63:40]}, 32'h0044_8002);

    // R9 privileged restore refused, entry unchanged
    run_cmd(1'b1, 2'd2, 8'h00, 8'h20, 1'b1, 1'b0, 2'd3, kind, nx, fv);
    chk("R9 TR restore cpl3 kind", 32'(kind), 32'd2);
    chk("R9 TR restore cpl3 transfers", 32'(nx), 32'd0);
    @(negedge clk);
    look_idx = 3'd6;
    #1;
    chk("R9 TR unchanged", look_base, 32'd0);

    // R8 TR restore in protected mode at cpl0 succeeds
    run_cmd(1'b1, 2'd2, 8'h00, 8'h20, 1'b1, 1'b0, 2'd0, kind, nx, fv);
    @(negedge clk);
    look_idx = 3'd6;
    #1;
    chk("R8 TR restored base", look_base, 32'hAB34_5678);
    chk("R8 TR restored selector", {16'd0, look_sel}, 32'h0123);

    // R7 LDT restore with free rm bits
    run_cmd(1'b1, 2'd1, 8'h05, 8'h30, 1'b1, 1'b0, 2'd0, kind, nx, fv);
    @(negedge clk);
    look_idx = 3'd5;
    #1;
    chk("R7 LDT restored limit", look_limit, 32'h20FF_FFFF);
    look_idx = 3'd7;
    #1;
    chk("R5 lookup index 7 reads zero", look_base, 32'd0);

    // R11 commit only after the last byte (SS restore, observed mid-transfer)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_restore = 1'b1; cmd_target = 2'd0; cmd_modrm = 8'h10;
    cmd_ea = 32'h20; prot_mode = 1'b0; v86_mode = 1'b0; cpl = 2'd0;
    look_idx = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk("R11 SS unchanged mid-restore", look_base, 32'd0);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk("R11 SS unchanged in done cycle", look_base, 32'd0);

    // R12 command raised in the done cycle is ignored
    x0 = xfers;
    cmd_valid = 1'b1; cmd_restore = 1'b1; cmd_target = 2'd0; cmd_modrm = 8'h00;
    cmd_ea = 32'h30;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 SS committed after done", look_base, 32'hAB34_5678);
    chk("R12 busy low after done", {31'd0, busy}, 32'd0);
    repeat (4) @(negedge clk);
    chk("R12 command in done cycle ignored", 32'(xfers - x0), 32'd0);
    look_idx = 3'd0;
    #1;
    chk("R12 ES not restored", look_base, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

endmodule